// File: doc/BRIEF.md
# Byte FIFO with Programmable Threshold Flags

A single-clock, byte-wide first-in first-out buffer. It accepts bytes through a write handshake and returns them in arrival order through a read handshake. Alongside the data path it reports the exact number of bytes held and the fixed capacity. Free space is capacity minus count.

Two programmable level flags help a producer or consumer size its bursts without polling empty and full. The low-water flag is measured upward from the empty end. The high-water flag is measured downward from the full end, so a value of N means "within N bytes of full". Both threshold values share one 32-bit word. A one-cycle load strobe updates that word, and the new values govern the flags from the following cycle, with no required ordering. Reset empties the buffer and restores both thresholds to 7.

Top module: `byte_fifo_almost`

## Requirements
- R1: While reset is held and after it is released, count is 0, empty is 1, full is 0, capacity equals DEPTH, and both thresholds hold 7. With those thresholds, almost_empty is 1 and almost_full is 0.
- R2: count equals accepted writes minus accepted reads. A write is accepted when wr_valid and wr_ready are both high, and a read when rd_valid and rd_ready are both high. empty is 1 exactly when count is 0, and full exactly when count equals DEPTH. wr_ready equals not full, and rd_valid equals not empty.
- R3: Bytes leave in the order they were accepted. rd_data shows the oldest stored byte while rd_valid is high.
- R4: A write while full is ignored: count and stored contents are unchanged.
- R5: A read while empty is ignored: count stays 0 and empty stays 1.
- R6: A read and a write accepted in the same cycle leave count unchanged.
- R7: almost_empty is 1 exactly when count <= thr_data bits [15:0] as last loaded.
- R8: almost_full is 1 exactly when count >= DEPTH - (thr_data bits [31:16] as last loaded). A value at or above DEPTH keeps the flag at 1.
- R9: When thr_load is high at a clock edge, both flags follow the new thr_data from the cycle after that edge.
- R10: With the default thresholds, almost_empty falls when the eighth byte is written and rises again when a read brings count back to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write request |
| wr_ready | output | 1 | Space available (not full) |
| wr_data | input | 8 | Byte to store |
| rd_valid | output | 1 | Data available (not empty) |
| rd_ready | input | 1 | Read request |
| rd_data | output | 8 | Oldest stored byte |
| thr_load | input | 1 | Load strobe for the threshold word |
| thr_data | input | 32 | [31:16] high-water distance from full, [15:0] low-water level |
| count | output | $clog2(DEPTH+1) | Bytes currently held |
| capacity | output | $clog2(DEPTH+1) | Configured depth |
| empty | output | 1 | No bytes held |
| full | output | 1 | DEPTH bytes held |
| almost_empty | output | 1 | Low-water flag |
| almost_full | output | 1 | High-water flag |

## Verification
The handshake outputs and rd_data are combinational from stored state, so they are due in the same cycle as the request. The bench compares them before the clock edge that would consume the request. Count, empty and full change one edge after an accepted transfer. The two flags follow count with no further delay and follow a threshold load one edge after the strobe, so every such comparison is made at the falling edge after that rising edge, against a model updated at that edge.

// File: rtl/bfa_pkg.sv
// Package bfa_pkg
// Shared types and constants for the byte FIFO with threshold flags.
// Assumes threshold fields are 16 bits wide and packed high-water over low-water.
package bfa_pkg;
    localparam int THR_W = 16;

    typedef struct packed {
        logic [THR_W-1:0] hi_dist;   // distance from full for almost_full
        logic [THR_W-1:0] lo_level;  // level at or below which almost_empty holds
    } thr_t;

    localparam logic [2*THR_W-1:0] THR_RESET = 32'h0007_0007;
endpackage

// File: rtl/bfa_thr_reg.sv
// Module bfa_thr_reg
// Holds the packed threshold word. A load strobe replaces it at the next edge.
// Assumes a synchronous active-low reset that restores the default word.
module bfa_thr_reg
    import bfa_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] din,
    output thr_t        thr
);
    // Capture a new threshold word on load, restore the default on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr <= thr_t'(THR_RESET);
        end else if (load) begin
            thr <= thr_t'(din);
        end
    end
endmodule

// File: rtl/bfa_ctrl.sv
// Module bfa_ctrl
// Pointer and occupancy control. Gates requests against full and empty,
// advances wrapping pointers and keeps the exact byte count.
// Assumes DEPTH >= 2. DEPTH need not be a power of two.
module bfa_ctrl #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    // Advance a pointer, wrapping after the last slot.
    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    // Status and request gating from the current count.
    always_comb begin
        empty = (count == '0);
        full  = (count == FULL_CNT);
        push  = push_req && !full;
        pop   = pop_req && !empty;
    end

    // Update pointers and count for accepted transfers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/bfa_mem.sv
// Module bfa_mem
// Byte storage array with one synchronous write port and one combinational
// read port. Assumes the controller never writes a slot still unread.
module bfa_mem #(
    parameter int DEPTH = 1024,
    parameter int DW = 8,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Write an accepted byte into its slot.
    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    // Present the slot at the read pointer.
    assign rdata = store[raddr];
endmodule

// File: rtl/bfa_flags.sv
// Module bfa_flags
// Level flags from the count and the threshold word. Low-water compares upward
// from empty. High-water compares downward from full, done as count + distance
// >= DEPTH so that a distance at or above DEPTH cannot underflow.
module bfa_flags
    import bfa_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int SW = ((CW > THR_W) ? CW : THR_W) + 2
) (
    input  logic [CW-1:0] count,
    input  thr_t          thr,
    output logic          almost_empty,
    output logic          almost_full
);
    localparam logic [SW-1:0] CAP = SW'(DEPTH);

    // Compare the count against both thresholds in a widened domain.
    always_comb begin
        almost_empty = SW'(count) <= SW'(thr.lo_level);
        almost_full  = (SW'(count) + SW'(thr.hi_dist)) >= CAP;
    end
endmodule

// File: rtl/byte_fifo_almost.sv
// Module byte_fifo_almost
// Top level of the byte FIFO with live count and programmable threshold flags.
// Assumes one clock, synchronous active-low reset and DEPTH >= 2.
module byte_fifo_almost
    import bfa_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int DW = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [DW-1:0] wr_data,
    output logic          rd_valid,
    input  logic          rd_ready,
    output logic [DW-1:0] rd_data,
    input  logic          thr_load,
    input  logic [31:0]   thr_data,
    output logic [CW-1:0] count,
    output logic [CW-1:0] capacity,
    output logic          empty,
    output logic          full,
    output logic          almost_empty,
    output logic          almost_full
);
    logic          push, pop;
    logic [AW-1:0] wr_ptr, rd_ptr;
    thr_t          thr;

    bfa_thr_reg u_thr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (thr_load),
        .din   (thr_data),
        .thr   (thr)
    );

    bfa_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (wr_valid),
        .pop_req  (rd_ready),
        .push     (push),
        .pop      (pop),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .count    (count),
        .empty    (empty),
        .full     (full)
    );

    bfa_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
        .clk   (clk),
        .we    (push),
        .waddr (wr_ptr),
        .wdata (wr_data),
        .raddr (rd_ptr),
        .rdata (rd_data)
    );

    bfa_flags #(.DEPTH(DEPTH)) u_flags (
        .count        (count),
        .thr          (thr),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    // Handshake outputs and the fixed capacity.
    assign wr_ready = !full;
    assign rd_valid = !empty;
    assign capacity = CW'(DEPTH);
endmodule

// File: rtl/bfa_checker.sv
// Module bfa_checker
// Temporal checks on the FIFO ports, attached to every byte_fifo_almost by bind.
module bfa_checker #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          rd_ready,
    input logic          thr_load,
    input logic [31:0]   thr_data,
    input logic [CW-1:0] count,
    input logic          empty,
    input logic          full,
    input logic          almost_empty,
    input logic          almost_full
);
    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1)
                 || (count == $past(count) - 1'b1));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= 32'(DEPTH));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && !rd_ready) |=> (count == $past(count)) && full);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_ready && !wr_valid) |=> (count == '0) && empty);

    // R6
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_ready && !empty && !full) |=> $stable(count));

    // R9
    lo_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> almost_empty == (32'(count) <= 32'($past(thr_data[15:0]))));

    // R9
    hi_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        thr_load |=> almost_full ==
            ((32'(count) + 32'($past(thr_data[31:16]))) >= 32'(DEPTH)));
endmodule

bind byte_fifo_almost bfa_checker #(.DEPTH(DEPTH)) u_bfa_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .rd_ready     (rd_ready),
    .thr_load     (thr_load),
    .thr_data     (thr_data),
    .count        (count),
    .empty        (empty),
    .full         (full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
);

// File: tb/test_byte_fifo_almost.sv
// Bench for byte_fifo_almost: directed corners plus seeded random traffic,
// compared against a queue model and threshold functions.
module test_byte_fifo_almost;
    localparam int DEPTH = 64;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [31:0] THR_DEF = 32'h0007_0007;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_valid, rd_ready, thr_load;
    logic [7:0]    wr_data;
    logic [31:0]   thr_data;
    logic          wr_ready, rd_valid, empty, full, almost_empty, almost_full;
    logic [7:0]    rd_data;
    logic [CW-1:0] count, capacity;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [7:0]  q[$];
    logic [31:0] thr_m = THR_DEF;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    byte_fifo_almost #(.DEPTH(DEPTH)) i_byte_fifo_almost (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .thr_load(thr_load), .thr_data(thr_data),
        .count(count), .capacity(capacity), .empty(empty), .full(full),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic exp_ae(input int c, input logic [31:0] t);
        return c <= int'(t[15:0]);
    endfunction

    function automatic logic exp_af(input int c, input logic [31:0] t);
        return (c + int'(t[31:16])) >= DEPTH;
    endfunction

    // One clock of stimulus, entered and left at a falling edge.
    task automatic cyc(input logic wv, input logic [7:0] wd, input logic rr,
                       input logic tl, input logic [31:0] td);
        bit push, pop;
        string ct;
        wr_valid = wv; wr_data = wd; rd_ready = rr; thr_load = tl; thr_data = td;
        #1;
        chk("R2", "wr_ready", wr_ready, q.size() < DEPTH);
        chk("R2", "rd_valid", rd_valid, q.size() > 0);
        push = wv && (q.size() < DEPTH);
        pop  = rr && (q.size() > 0);
        if (pop) chk("R3", "rd_data", rd_data, q[0]);
        ct = (push && pop) ? "R6" : (wv && !push) ? "R4" : (rr && !pop) ? "R5" : "R2";
        @(posedge clk);
        if (pop)  void'(q.pop_front());
        if (push) q.push_back(wd);
        if (tl)   thr_m = td;
        @(negedge clk);
        wr_valid = 1'b0; rd_ready = 1'b0; thr_load = 1'b0;
        chk(ct, "count", count, q.size());
        chk(ct, "empty", empty, q.size() == 0);
        chk(ct, "full", full, q.size() == DEPTH);
        chk(tl ? "R9" : "R7", "almost_empty", almost_empty, exp_ae(q.size(), thr_m));
        chk(tl ? "R9" : "R8", "almost_full", almost_full, exp_af(q.size(), thr_m));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_valid = 1'b0; rd_ready = 1'b0; thr_load = 1'b0;
        wr_data = '0; thr_data = '0;
        repeat (3) @(negedge clk);
        chk("R1", "count in reset", count, 0);
        rst_n = 1'b1;
        q.delete();
        thr_m = THR_DEF;
        @(negedge clk);
        chk("R1", "count", count, 0);
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "capacity", capacity, DEPTH);
        chk("R1", "almost_empty", almost_empty, 1);
        chk("R1", "almost_full", almost_full, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int pw;
        int pr;
        void'($urandom(32'd4711));
        do_reset();

        // R10: low-water edge with default thresholds
        for (int i = 0; i < 7; i++) cyc(1, 8'(i + 1), 0, 0, 0);
        chk("R10", "ae at 7", almost_empty, 1);
        cyc(1, 8'h08, 0, 0, 0);
        chk("R10", "ae at 8", almost_empty, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R10", "ae back at 7", almost_empty, 1);

        // R8: fill to full, high-water edge at DEPTH-7
        while (q.size() < DEPTH) begin
            cyc(1, 8'($urandom), 0, 0, 0);
            if (q.size() == DEPTH - 8) chk("R8", "af at DEPTH-8", almost_full, 0);
            if (q.size() == DEPTH - 7) chk("R8", "af at DEPTH-7", almost_full, 1);
        end
        // R4: writes while full
        cyc(1, 8'hAA, 0, 0, 0);
        cyc(1, 8'h55, 0, 0, 0);
        // read and write together while full: only the read is taken
        cyc(1, 8'h5A, 1, 0, 0);
        cyc(1, 8'hC3, 0, 0, 0);
        // R6: simultaneous transfer in the middle
        cyc(0, 0, 1, 0, 0);
        cyc(1, 8'h3C, 1, 0, 0);
        // drain and R5: reads while empty
        while (q.size() > 0) cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);
        // write while empty with read request: only write is taken
        cyc(1, 8'h77, 1, 0, 0);
        cyc(0, 0, 1, 0, 0);

        // R9: new thresholds, high-water distance beyond capacity
        cyc(0, 0, 0, 1, {16'd100, 16'd20});
        chk("R9", "af forced", almost_full, 1);
        cyc(0, 0, 0, 1, {16'd0, 16'd0});
        chk("R9", "af zero dist", almost_full, 0);
        chk("R9", "ae zero level", almost_empty, 1);
        cyc(1, 8'h11, 0, 1, {16'd3, 16'd2});

        // random traffic with alternating fill and drain bias
        for (int n = 0; n < 6000; n++) begin
            pw = ((n / 400) % 2 == 0) ? 75 : 30;
            pr = ((n / 400) % 2 == 0) ? 30 : 75;
            cyc($urandom_range(0, 99) < pw, 8'($urandom),
                $urandom_range(0, 99) < pr,
                $urandom_range(0, 99) < 3,
                {16'($urandom_range(0, 70)), 16'($urandom_range(0, 70))});
        end

        // R1: reset again restores default thresholds and empties
        cyc(1, 8'h01, 0, 1, {16'd50, 16'd50});
        do_reset();
        cyc(1, 8'h99, 0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule